// File: doc/BRIEF.md
# Sub-word Write-Combining Register Bridge

This block connects a bus master that issues byte, halfword and word register accesses to a peripheral register file that only accepts aligned 32-bit reads and writes. A narrow write becomes a read of the containing word, a lane replacement and a write of the whole word back. A narrow read becomes a word read followed by extraction of the addressed lane.

Four halfword registers get special treatment so that back-to-back writes to the same downstream word are avoided. These are block size, block count, transfer mode and command. Writes to block size, block count and transfer mode are parked in two shadow words. A command halfword write then flushes them as at most two full-word writes: the block word first, then the transfer-mode and command word together.

After each downstream write the bridge waits for the peripheral to settle when its card clock is slow. The wait is timed in bridge clock cycles from the card clock frequency, which is an input to the block.

Top module: `wcb_bridge`

## Requirements
- R1: Every downstream access carries a word-aligned address, with the low two bits zero. A byte lane sits at bit 8×addr[1:0], and a halfword lane sits at bit 0 or 16 according to addr[1]. On the upstream side, up_size uses 0 for byte, 1 for halfword and 2 for word. Narrow write data sits in the low bits of up_wdata.
- R2: A byte write reads the containing word, changes only the addressed byte, and writes the word back.
- R3: A 32-bit write goes out as one unchanged downstream write. A halfword write to any register other than 0x04, 0x06, 0x0C or 0x0E is a read-modify-write of its containing word.
- R4: A halfword write to 0x04 (block size) or 0x06 (block count) causes no downstream write. It is merged into the block shadow and marks that shadow valid. The merge base is a downstream read of word 0x04 when the shadow is not yet valid, and the shadow itself, with no downstream access, when it is valid.
- R5: A halfword write to 0x0C (transfer mode) causes no downstream write. It reads word 0x0C, merges the halfword into it, stores the result as the command shadow, and marks that shadow valid.
- R6: A halfword write to 0x0E (command) acts in this order. If the block shadow is valid, that shadow is first written to 0x04 and its flag is cleared. Next, the command halfword is merged into the command shadow, which is the base whether or not its flag is set, and the result is written to 0x0C. The command flag is cleared.
- R7: A halfword read of 0x0C while the command shadow is valid returns the shadow's lane. A halfword read of 0x04 or 0x06 while the block shadow is valid returns the block shadow's lane. Neither read causes a downstream access, and up_rvalid rises in the cycle after acceptance.
- R8: Every other read returns the addressed lane of a downstream word read, zero-extended in up_rdata. up_rvalid is a single-cycle pulse.
- R9: After each downstream write, up_ready stays low for N more cycles, where N is the wait in microseconds times CYC_PER_US. The wait is ceil(4,000,000 / card_hz) µs when card_hz is at most 400,000. It is 10 µs when card_hz is 0. It is 0 above 400,000.
- R10: up_ready is low for the whole of any multi-step sequence. A downstream request holds its address and direction until it is acknowledged.
- R11: After reset, both shadows are invalid with zero contents, up_ready is high, and no downstream request or read response is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req | input | 1 | Upstream access request |
| up_we | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_addr | input | AW | Byte address |
| up_wdata | input | 32 | Write data, narrow values in the low bits |
| up_ready | output | 1 | Request accepted when high together with up_req |
| up_rvalid | output | 1 | One-cycle read-data strobe |
| up_rdata | output | 32 | Read data, lane zero-extended |
| card_hz | input | 32 | Configured card clock frequency in Hz |
| dn_req | output | 1 | Downstream request, held until acknowledged |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | AW | Downstream word-aligned address |
| dn_wdata | output | 32 | Downstream write word |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read word, valid with dn_ack |

## Verification
The bench builds the bridge with AW = 8 and CYC_PER_US = 2. This keeps the settle windows short enough to count exactly: 20 cycles at 400 kHz and at 0 Hz, 28 cycles at 300 kHz, and none at 400,001 Hz. The address space still reaches all four special halfword offsets. A downstream word memory with one-cycle acknowledge lets the bench count downstream reads, which shows which reads are answered from the shadows and which merge bases come from the peripheral.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

    localparam int WORD_W = 32;

    // Halfword registers with special handling (byte offsets)
    localparam logic [7:0] OFS_BLK_SIZE  = 8'h04;
    localparam logic [7:0] OFS_BLK_COUNT = 8'h06;
    localparam logic [7:0] OFS_XFER_MODE = 8'h0C;
    localparam logic [7:0] OFS_COMMAND   = 8'h0E;

    localparam int SHADOW_SLOTS = 2;
    localparam int SLOT_BLK     = 0;
    localparam int SLOT_CMD     = 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SETTLE
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_RMW,
        OP_BLK,
        OP_XFER
    } op_e;

    typedef struct packed {
        logic [1:0] ofs;
        acc_size_e  size;
        word_t      data;
    } lane_req_t;

    function automatic logic [4:0] lane_shift(lane_req_t r);
        case (r.size)
            ACC_BYTE: return {r.ofs, 3'b000};
            ACC_HALF: return {r.ofs[1], 4'b0000};
            default:  return 5'd0;
        endcase
    endfunction

    function automatic word_t lane_mask(acc_size_e s);
        case (s)
            ACC_BYTE: return word_t'(32'h0000_00FF);
            ACC_HALF: return word_t'(32'h0000_FFFF);
            default:  return '1;
        endcase
    endfunction

    function automatic word_t lane_merge(word_t base, lane_req_t r);
        word_t      m;
        logic [4:0] sh;
        m  = lane_mask(r.size);
        sh = lane_shift(r);
        return (base & ~(m << sh)) | ((r.data & m) << sh);
    endfunction

    function automatic word_t lane_extract(word_t w, lane_req_t r);
        return (w >> lane_shift(r)) & lane_mask(r.size);
    endfunction

endpackage

// File: rtl/wcb_shadow_slot.sv
module wcb_shadow_slot
    import wcb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_data,
    input  logic  inval,
    output word_t word_q,
    output logic  valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_en) begin
            word_q  <= wr_data;
            valid_q <= 1'b1;
        end else if (inval) begin
            valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wcb_shadow_bank.sv
module wcb_shadow_bank
    import wcb_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [SHADOW_SLOTS-1:0]              wr_en,
    input  logic [SHADOW_SLOTS-1:0][WORD_W-1:0]  wr_data,
    input  logic [SHADOW_SLOTS-1:0]              inval,
    output logic [SHADOW_SLOTS-1:0][WORD_W-1:0]  words,
    output logic [SHADOW_SLOTS-1:0]              valids
);
    for (genvar g = 0; g < SHADOW_SLOTS; g++) begin : g_slot
        wcb_shadow_slot i_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en[g]),
            .wr_data (wr_data[g]),
            .inval   (inval[g]),
            .word_q  (words[g]),
            .valid_q (valids[g])
        );
    end
endmodule

// File: rtl/wcb_settle_timer.sv
module wcb_settle_timer #(
    parameter int CYC_PER_US    = 50,
    parameter int SLOW_LIMIT_HZ = 400000,
    parameter int SLOW_PERIODS  = 4,
    parameter int IDLE_WAIT_US  = 10,
    parameter int CNT_W         = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] card_hz,
    input  logic        start,
    output logic        wait_needed,
    output logic        last_tick
);
    localparam logic [31:0] PERIOD_NUM = 32'(SLOW_PERIODS * 1000000);

    logic [31:0]      wait_us;
    logic [31:0]      wait_cyc;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        if (card_hz == 32'd0) begin
            wait_us = 32'(IDLE_WAIT_US);
        end else if (card_hz <= 32'(SLOW_LIMIT_HZ)) begin
            wait_us = (PERIOD_NUM + card_hz - 32'd1) / card_hz;
        end else begin
            wait_us = 32'd0;
        end
        wait_cyc = wait_us * 32'(CYC_PER_US);
    end

    assign wait_needed = (wait_cyc != 32'd0);
    assign last_tick   = (cnt_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CNT_W'(wait_cyc);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/wcb_bridge.sv
module wcb_bridge
    import wcb_pkg::*;
#(
    parameter int AW            = 8,
    parameter int CYC_PER_US    = 50,
    parameter int SLOW_LIMIT_HZ = 400000,
    parameter int SLOW_PERIODS  = 4,
    parameter int IDLE_WAIT_US  = 10,
    parameter int CNT_W         = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_req,
    input  logic          up_we,
    input  logic [1:0]    up_size,
    input  logic [AW-1:0] up_addr,
    input  logic [31:0]   up_wdata,
    output logic          up_ready,
    output logic          up_rvalid,
    output logic [31:0]   up_rdata,
    input  logic [31:0]   card_hz,
    output logic          dn_req,
    output logic          dn_we,
    output logic [AW-1:0] dn_addr,
    output logic [31:0]   dn_wdata,
    input  logic          dn_ack,
    input  logic [31:0]   dn_rdata
);
    localparam logic [AW-1:0] A_BLK_SIZE  = AW'(OFS_BLK_SIZE);
    localparam logic [AW-1:0] A_BLK_COUNT = AW'(OFS_BLK_COUNT);
    localparam logic [AW-1:0] A_XFER      = AW'(OFS_XFER_MODE);
    localparam logic [AW-1:0] A_CMD       = AW'(OFS_COMMAND);
    localparam logic [AW-1:0] A_BLK_WORD  = {A_BLK_SIZE[AW-1:2], 2'b00};
    localparam logic [AW-1:0] A_CMD_WORD  = {A_CMD[AW-1:2], 2'b00};

    // Sequencer state
    seq_state_e    state_q, state_n;
    op_e           op_q, op_n;
    lane_req_t     lat_q, lat_n;
    logic [AW-1:0] addr_q, addr_n;
    word_t         wd_q, wd_n;
    logic          pend_q, pend_n;
    logic          rv_q, rv_n;
    word_t         rd_q, rd_n;

    // Shadow bank interface
    logic [SHADOW_SLOTS-1:0]             sh_we, sh_inval, sh_valid;
    logic [SHADOW_SLOTS-1:0][WORD_W-1:0] sh_wd, sh_word;

    // Settle timer interface
    logic t_start, t_need, t_last;

    // Request decode
    lane_req_t     req_lane;
    logic [AW-1:0] req_word_addr;
    logic          is_half, hit_blk, hit_xfer, hit_cmd, go_next;

    assign req_lane      = '{ofs: up_addr[1:0], size: acc_size_e'(up_size), data: up_wdata};
    assign req_word_addr = {up_addr[AW-1:2], 2'b00};
    assign is_half       = (up_size == ACC_HALF);
    assign hit_blk       = is_half && ((up_addr == A_BLK_SIZE) || (up_addr == A_BLK_COUNT));
    assign hit_xfer      = is_half && (up_addr == A_XFER);
    assign hit_cmd       = is_half && (up_addr == A_CMD);

    wcb_shadow_bank i_shadow (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sh_we),
        .wr_data (sh_wd),
        .inval   (sh_inval),
        .words   (sh_word),
        .valids  (sh_valid)
    );

    wcb_settle_timer #(
        .CYC_PER_US    (CYC_PER_US),
        .SLOW_LIMIT_HZ (SLOW_LIMIT_HZ),
        .SLOW_PERIODS  (SLOW_PERIODS),
        .IDLE_WAIT_US  (IDLE_WAIT_US),
        .CNT_W         (CNT_W)
    ) i_settle (
        .clk         (clk),
        .rst         (rst),
        .card_hz     (card_hz),
        .start       (t_start),
        .wait_needed (t_need),
        .last_tick   (t_last)
    );

    always_comb begin
        state_n  = state_q;
        op_n     = op_q;
        lat_n    = lat_q;
        addr_n   = addr_q;
        wd_n     = wd_q;
        pend_n   = pend_q;
        rv_n     = 1'b0;
        rd_n     = rd_q;
        sh_we    = '0;
        sh_inval = '0;
        sh_wd    = sh_word;
        t_start  = 1'b0;
        go_next  = 1'b0;

        case (state_q)
            ST_IDLE: begin
                if (up_req) begin
                    lat_n = req_lane;
                    if (!up_we) begin
                        if (hit_xfer && sh_valid[SLOT_CMD]) begin
                            rv_n = 1'b1;
                            rd_n = lane_extract(sh_word[SLOT_CMD], req_lane);
                        end else if (hit_blk && sh_valid[SLOT_BLK]) begin
                            rv_n = 1'b1;
                            rd_n = lane_extract(sh_word[SLOT_BLK], req_lane);
                        end else begin
                            op_n    = OP_READ;
                            addr_n  = req_word_addr;
                            state_n = ST_RD;
                        end
                    end else if (up_size[1]) begin
                        addr_n  = req_word_addr;
                        wd_n    = up_wdata;
                        state_n = ST_WR;
                    end else if (hit_cmd) begin
                        sh_inval[SLOT_CMD] = 1'b1;
                        state_n            = ST_WR;
                        if (sh_valid[SLOT_BLK]) begin
                            sh_inval[SLOT_BLK] = 1'b1;
                            pend_n             = 1'b1;
                            addr_n             = A_BLK_WORD;
                            wd_n               = sh_word[SLOT_BLK];
                        end else begin
                            addr_n = A_CMD_WORD;
                            wd_n   = lane_merge(sh_word[SLOT_CMD], req_lane);
                        end
                    end else if (hit_blk && sh_valid[SLOT_BLK]) begin
                        sh_we[SLOT_BLK] = 1'b1;
                        sh_wd[SLOT_BLK] = lane_merge(sh_word[SLOT_BLK], req_lane);
                    end else begin
                        addr_n  = req_word_addr;
                        state_n = ST_RD;
                        if (hit_blk)       op_n = OP_BLK;
                        else if (hit_xfer) op_n = OP_XFER;
                        else               op_n = OP_RMW;
                    end
                end
            end

            ST_RD: begin
                if (dn_ack) begin
                    case (op_q)
                        OP_READ: begin
                            rv_n    = 1'b1;
                            rd_n    = lane_extract(dn_rdata, lat_q);
                            state_n = ST_IDLE;
                        end
                        OP_BLK: begin
                            sh_we[SLOT_BLK] = 1'b1;
                            sh_wd[SLOT_BLK] = lane_merge(dn_rdata, lat_q);
                            state_n         = ST_IDLE;
                        end
                        OP_XFER: begin
                            sh_we[SLOT_CMD] = 1'b1;
                            sh_wd[SLOT_CMD] = lane_merge(dn_rdata, lat_q);
                            state_n         = ST_IDLE;
                        end
                        default: begin
                            wd_n    = lane_merge(dn_rdata, lat_q);
                            state_n = ST_WR;
                        end
                    endcase
                end
            end

            ST_WR: begin
                if (dn_ack) begin
                    t_start = 1'b1;
                    if (t_need) state_n = ST_SETTLE;
                    else        go_next = 1'b1;
                end
            end

            ST_SETTLE: begin
                if (t_last) go_next = 1'b1;
            end

            default: state_n = ST_IDLE;
        endcase

        // After a write (and its settle), either issue the pending command
        // word or return to idle.
        if (go_next) begin
            if (pend_q) begin
                pend_n  = 1'b0;
                addr_n  = A_CMD_WORD;
                wd_n    = lane_merge(sh_word[SLOT_CMD], lat_q);
                state_n = ST_WR;
            end else begin
                state_n = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_READ;
            lat_q   <= '0;
            addr_q  <= '0;
            wd_q    <= '0;
            pend_q  <= 1'b0;
            rv_q    <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_n;
            op_q    <= op_n;
            lat_q   <= lat_n;
            addr_q  <= addr_n;
            wd_q    <= wd_n;
            pend_q  <= pend_n;
            rv_q    <= rv_n;
            rd_q    <= rd_n;
        end
    end

    assign up_ready  = (state_q == ST_IDLE);
    assign up_rvalid = rv_q;
    assign up_rdata  = rd_q;
    assign dn_req    = (state_q == ST_RD) || (state_q == ST_WR);
    assign dn_we     = (state_q == ST_WR);
    assign dn_addr   = addr_q;
    assign dn_wdata  = wd_q;

endmodule

// File: rtl/wcb_bridge_checker.sv
module wcb_bridge_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          up_ready,
    input logic          up_rvalid,
    input logic          dn_req,
    input logic          dn_we,
    input logic          dn_ack,
    input logic [AW-1:0] dn_addr
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> (dn_addr[1:0] == 2'b00));

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (dn_req && !dn_ack) |=> (dn_req && $stable(dn_addr) && $stable(dn_we)));

    assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
        dn_req |-> !up_ready);

    assert_rvalid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        up_rvalid |=> !up_rvalid);

    always @(posedge clk) begin
        if (rst_d === 1'b1 && !rst) begin
            assert_reset_R11: assert (up_ready && !dn_req && !up_rvalid);
        end
    end
endmodule

bind wcb_bridge wcb_bridge_checker #(.AW(AW)) i_wcb_checker (
    .clk       (clk),
    .rst       (rst),
    .up_ready  (up_ready),
    .up_rvalid (up_rvalid),
    .dn_req    (dn_req),
    .dn_we     (dn_we),
    .dn_ack    (dn_ack),
    .dn_addr   (dn_addr)
);

// File: tb/test_wcb_bridge.sv
module test_wcb_bridge;
    localparam int AW  = 8;
    localparam int CPU = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          up_req = 1'b0, up_we = 1'b0;
    logic [1:0]    up_size = 2'd0;
    logic [AW-1:0] up_addr = '0;
    logic [31:0]   up_wdata = '0;
    logic          up_ready, up_rvalid;
    logic [31:0]   up_rdata;
    logic [31:0]   card_hz = 32'd50_000_000;
    logic          dn_req, dn_we, dn_ack;
    logic [AW-1:0] dn_addr;
    logic [31:0]   dn_wdata, dn_rdata;

    always #10 clk = ~clk;   // 50 MHz

    wcb_bridge #(.AW(AW), .CYC_PER_US(CPU)) i_wcb_bridge (
        .clk(clk), .rst(rst),
        .up_req(up_req), .up_we(up_we), .up_size(up_size), .up_addr(up_addr),
        .up_wdata(up_wdata), .up_ready(up_ready), .up_rvalid(up_rvalid),
        .up_rdata(up_rdata), .card_hz(card_hz),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_ack(dn_ack), .dn_rdata(dn_rdata)
    );

    // Downstream register file model, one-cycle acknowledge
    logic [31:0] mem [16];
    assign dn_rdata = mem[dn_addr[5:2]];

    always @(posedge clk) begin
        if (rst) begin
            dn_ack <= 1'b0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'(i) * 32'h0101_0101;
            mem[1] <= 32'hAABB_CCDD;
            mem[3] <= 32'h7777_1111;
            mem[8] <= 32'h1111_2222;
        end else begin
            dn_ack <= dn_req && !dn_ack;
            if (dn_req && dn_ack && dn_we) mem[dn_addr[5:2]] <= dn_wdata;
        end
    end

    int checks = 0;
    int errors = 0;
    int dn_reads = 0;

    logic [AW-1:0] exp_addr [$];
    logic [31:0]   exp_data [$];
    string         exp_tag  [$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each downstream write with the queue
    always @(negedge clk) begin
        if (!rst && dn_req && dn_ack) begin
            if (dn_we) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R10 unexpected downstream write", dn_wdata, 32'h0);
                end else begin
                    logic [AW-1:0] ea;
                    logic [31:0]   ed;
                    string         et;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    et = exp_tag.pop_front();
                    chk(dn_addr == ea, {et, " address"}, 32'(dn_addr), 32'(ea));
                    chk(dn_wdata == ed, {et, " data"}, dn_wdata, ed);
                end
            end else begin
                dn_reads++;
            end
        end
    end

    task automatic expect_wr(input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        exp_addr.push_back(a);
        exp_data.push_back(d);
        exp_tag.push_back(tag);
    endtask

    task automatic access(input bit we, input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        up_req = 1'b1; up_we = we; up_size = sz; up_addr = a; up_wdata = wd;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_req = 1'b0;
        rd = '0;
        if (!we) begin
            while (!up_rvalid) @(negedge clk);
            rd = up_rdata;
        end
    endtask

    task automatic wait_idle();
        while (!up_ready) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sz, input logic [AW-1:0] a, input logic [31:0] wd);
        logic [31:0] dummy;
        access(1'b1, sz, a, wd, dummy);
    endtask

    task automatic rd_chk(input logic [1:0] sz, input logic [AW-1:0] a,
                          input logic [31:0] exp, input string tag);
        logic [31:0] r;
        access(1'b0, sz, a, 32'h0, r);
        chk(r == exp, tag, r, exp);
    endtask

    task automatic settle_chk(input logic [31:0] hz, input int exp_n, input string tag);
        int n;
        wait_idle();
        card_hz = hz;
        expect_wr(8'h30, hz ^ 32'h5A5A_0000, {tag, " write"});
        @(negedge clk);
        up_req = 1'b1; up_we = 1'b1; up_size = 2'd2; up_addr = 8'h30;
        up_wdata = hz ^ 32'h5A5A_0000;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_req = 1'b0;
        while (!(dn_req && dn_ack && dn_we)) @(negedge clk);
        n = 0;
        @(negedge clk);
        while (!up_ready) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_n, tag, 32'(n), 32'(exp_n));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int r0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(up_ready && !dn_req && !up_rvalid, "R11 idle after reset",
            {29'd0, up_ready, dn_req, up_rvalid}, 32'h4);

        // R8/R11: shadows invalid after reset, so halfword reads go downstream
        r0 = dn_reads;
        rd_chk(2'd1, 8'h04, 32'h0000_CCDD, "R8 half read 0x04");
        chk(dn_reads == r0 + 1, "R11 block shadow invalid at reset", 32'(dn_reads), 32'(r0 + 1));
        rd_chk(2'd1, 8'h06, 32'h0000_AABB, "R8 half read 0x06");
        rd_chk(2'd0, 8'h07, 32'h0000_00AA, "R8 byte read 0x07");
        rd_chk(2'd2, 8'h04, 32'hAABB_CCDD, "R8 word read 0x04");

        // R3: word write passes through
        expect_wr(8'h10, 32'h1234_5678, "R3 word write");
        wr(2'd2, 8'h10, 32'h1234_5678);
        rd_chk(2'd2, 8'h10, 32'h1234_5678, "R3 word readback");

        // R2: byte write replaces lane 1 only; R10: busy during the sequence
        expect_wr(8'h10, 32'h1234_9A78, "R2 byte rmw");
        wr(2'd0, 8'h11, 32'h0000_009A);
        chk(!up_ready && dn_req, "R10 ready low during rmw", {30'd0, up_ready, dn_req}, 32'h1);
        wait_idle();

        // R3: halfword write to an ordinary register
        expect_wr(8'h20, 32'h5555_2222, "R3 half rmw");
        wr(2'd1, 8'h22, 32'h0000_5555);
        rd_chk(2'd0, 8'h13, 32'h0000_0012, "R8 byte read lane 3");

        // R4: block shadow
        wait_idle();
        r0 = dn_reads;
        wr(2'd1, 8'h04, 32'h0000_0200);
        wait_idle();
        chk(dn_reads == r0 + 1, "R4 first merge base read", 32'(dn_reads), 32'(r0 + 1));
        r0 = dn_reads;
        rd_chk(2'd1, 8'h06, 32'h0000_AABB, "R7 block count from shadow");
        chk(dn_reads == r0, "R7 no downstream read for shadow", 32'(dn_reads), 32'(r0));
        wr(2'd1, 8'h06, 32'h0000_0008);
        wait_idle();
        chk(dn_reads == r0, "R4 second merge uses shadow", 32'(dn_reads), 32'(r0));
        rd_chk(2'd1, 8'h04, 32'h0000_0200, "R7 block size from shadow");
        rd_chk(2'd2, 8'h04, 32'hAABB_CCDD, "R4 peripheral word unchanged");

        // R5: transfer mode shadow
        r0 = dn_reads;
        wr(2'd1, 8'h0C, 32'h0000_0023);
        wait_idle();
        chk(dn_reads == r0 + 1, "R5 merge base read of 0x0C", 32'(dn_reads), 32'(r0 + 1));
        rd_chk(2'd1, 8'h0C, 32'h0000_0023, "R7 transfer mode from shadow");
        rd_chk(2'd2, 8'h0C, 32'h7777_1111, "R5 peripheral word unchanged");

        // R6: command flush order
        expect_wr(8'h04, 32'h0008_0200, "R6 block flush");
        expect_wr(8'h0C, 32'h1234_0023, "R6 command word");
        wr(2'd1, 8'h0E, 32'h0000_1234);
        wait_idle();
        chk(exp_data.size() == 0, "R6 both writes issued", 32'(exp_data.size()), 32'h0);
        r0 = dn_reads;
        rd_chk(2'd1, 8'h04, 32'h0000_0200, "R6 block flag cleared");
        chk(dn_reads == r0 + 1, "R6 block read goes downstream", 32'(dn_reads), 32'(r0 + 1));
        r0 = dn_reads;
        rd_chk(2'd1, 8'h0C, 32'h0000_0023, "R6 command flag cleared");
        chk(dn_reads == r0 + 1, "R6 xfer read goes downstream", 32'(dn_reads), 32'(r0 + 1));

        // R6: merge base is the shadow even when its flag is clear
        expect_wr(8'h0C, 32'h0000_9999, "R3 word write 0x0C");
        wr(2'd2, 8'h0C, 32'h0000_9999);
        expect_wr(8'h0C, 32'h0055_0023, "R6 command base from stale shadow");
        wr(2'd1, 8'h0E, 32'h0000_0055);
        wait_idle();

        // R9: settle windows (CPU = 2 cycles per microsecond)
        settle_chk(32'd400000, 20, "R9 400kHz");
        settle_chk(32'd300000, 28, "R9 300kHz");
        settle_chk(32'd0,      20, "R9 zero frequency");
        settle_chk(32'd400001, 0,  "R9 above limit");
        settle_chk(32'd50_000_000, 0, "R9 fast clock");

        wait_idle();
        repeat (2) @(negedge clk);
        chk(exp_data.size() == 0, "R10 scoreboard drained", 32'(exp_data.size()), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule